// File: doc/BRIEF.md
# FIFO Read-Threshold Interrupt Generator

This block raises the programmed-I/O service interrupt for a 16-entry parallel-port FIFO that is drained by the host. It watches the FIFO fill level. It compares that level against a read threshold, which is derived from a programmable threshold register. When enough bytes are waiting, it raises a registered interrupt. Along with the interrupt it reports how many bytes the host may read in one burst. That burst is the whole FIFO when the FIFO is full at the moment the interrupt fires. Otherwise it is the threshold byte count.

The host controls the block through a small write port with two registers. The threshold register sits at address 0. The control register sits at address 1 and holds a DMA-enable bit and a service-mask bit. Interrupts are produced only in programmed-I/O operation, that is, with DMA disabled and the service bit clear. When an interrupt fires, the block sets the service bit itself, which latches the request. The host acknowledges by writing the control register. The condition is then evaluated again on the cycle after that write.

Top module: `fifo_rd_irq_gen`

## Requirements
- R1: After reset, `irq` is low and `burst_bytes` is 0. The threshold register, the DMA-enable bit and the service bit are all 0, so a full FIFO (level 16) raises an interrupt with no register write.
- R2: A write with `host_addr` = 0 stores `host_wdata[4:0]` as the programmed threshold P. The read threshold is then 16 − P bytes.
- R3: Any programmed threshold of 15 or above, 16 included, is stored as 15. The read threshold is then 1 byte.
- R4: With DMA-enable 0 and service bit 0, `irq` rises when `fifo_level` ≥ read threshold. It rises on the first clock edge at which that holds, so it follows a level change by one clock.
- R5: While DMA-enable is 1, no interrupt is raised, whatever the level.
- R6: On the edge where `irq` rises, `burst_bytes` becomes 16 if `fifo_level` is 16, and otherwise becomes the read threshold. While `irq` is low, `burst_bytes` is 0.
- R7: When an interrupt fires, the service bit is set to 1. `irq` and `burst_bytes` then hold their values through any change of `fifo_level` until the control register is written.
- R8: A write with `host_addr` = 1 loads DMA-enable from `host_wdata[0]` and the service bit from `host_wdata[1]`. It clears `irq` and `burst_bytes` on that edge. If the condition still holds, the interrupt fires again on the following edge.
- R9: A service bit of 1 written by the host masks the interrupt: `irq` stays low even with a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | 5 | Bytes currently held in the FIFO, 0 to 16 |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 1 | Register select: 0 threshold, 1 control |
| host_wdata | input | 5 | Write data |
| irq | output | 1 | Registered service interrupt |
| burst_bytes | output | 5 | Bytes the host may read in one burst, 0 when idle |

## Verification
Register writes take effect on the edge that samples them. A control write therefore clears `irq` on that same edge, and the refire or non-refire is visible one edge later. A level change reaches `irq` and `burst_bytes` after exactly one edge. The bench drives every input on the falling edge and samples on the falling edge that follows the number of rising edges each result needs. Before the edge it also confirms that the output has not yet moved. A sweep covers every programmed threshold from 0 to 16 against every level from 0 to 16, and the expected interrupt and burst size are computed from the threshold arithmetic. Directed sequences cover masking, DMA suppression, latching across level changes and rearming.

// File: rtl/fti_pkg.sv
package fti_pkg;

    // Register select values on the host write port
    typedef enum logic {
        FTI_REG_THR = 1'b0,
        FTI_REG_CTL = 1'b1
    } fti_reg_e;

    // Bit positions inside the control register write data
    localparam int unsigned FTI_CTL_DMA_BIT = 0;
    localparam int unsigned FTI_CTL_SVC_BIT = 1;

endpackage

// File: rtl/fti_thr_clamp.sv
// Saturates a written threshold so that any value at or above DEPTH-1
// (including DEPTH itself) is stored as DEPTH-1.
module fti_thr_clamp #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int TW = $clog2(DEPTH)
) (
    input  logic [CW-1:0] raw_val,
    output logic [TW-1:0] stored_val
);

    localparam logic [CW-1:0] TOP_RAW = CW'(DEPTH - 1);

    always_comb begin
        if (raw_val >= TOP_RAW) begin
            stored_val = TW'(DEPTH - 1);
        end else begin
            stored_val = raw_val[TW-1:0];
        end
    end

endmodule

// File: rtl/fti_level_cmp.sv
// Turns the stored threshold into a byte count and compares it with the
// FIFO level; proposes the burst size that would go with an interrupt.
module fti_level_cmp #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int TW = $clog2(DEPTH)
) (
    input  logic [TW-1:0] thr_val,
    input  logic [CW-1:0] level,
    output logic          level_met,
    output logic [CW-1:0] burst_cand
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [CW-1:0] rd_thr;
    logic          is_full;

    always_comb begin
        rd_thr     = FULL_LVL - CW'(thr_val);
        is_full    = (level >= FULL_LVL);
        level_met  = (level >= rd_thr);
        burst_cand = is_full ? FULL_LVL : rd_thr;
    end

endmodule

// File: rtl/fifo_rd_irq_gen.sv
module fifo_rd_irq_gen
    import fti_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int TW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fifo_level,
    input  logic          host_wr,
    input  logic          host_addr,
    input  logic [CW-1:0] host_wdata,
    output logic          irq,
    output logic [CW-1:0] burst_bytes
);

    typedef struct packed {
        logic [TW-1:0] thr;
        logic          dma;
        logic          svc;
        logic          irq;
        logic [CW-1:0] burst;
    } state_t;

    state_t s_d, s_q;

    logic [TW-1:0] thr_clamped;
    logic          level_met;
    logic [CW-1:0] burst_cand;
    logic          thr_wr;
    logic          ctl_wr;
    logic          fire;

    fti_thr_clamp #(.DEPTH(DEPTH)) u_clamp (
        .raw_val    (host_wdata),
        .stored_val (thr_clamped)
    );

    fti_level_cmp #(.DEPTH(DEPTH)) u_cmp (
        .thr_val    (s_q.thr),
        .level      (fifo_level),
        .level_met  (level_met),
        .burst_cand (burst_cand)
    );

    always_comb begin
        s_d    = s_q;
        thr_wr = host_wr && (host_addr == FTI_REG_THR);
        ctl_wr = host_wr && (host_addr == FTI_REG_CTL);
        fire   = !s_q.dma && !s_q.svc && level_met;

        if (fire) begin
            s_d.svc   = 1'b1;
            s_d.irq   = 1'b1;
            s_d.burst = burst_cand;
        end

        if (thr_wr) begin
            s_d.thr = thr_clamped;
        end

        // A control write acknowledges any pending request
        if (ctl_wr) begin
            s_d.dma   = host_wdata[FTI_CTL_DMA_BIT];
            s_d.svc   = host_wdata[FTI_CTL_SVC_BIT];
            s_d.irq   = 1'b0;
            s_d.burst = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq         = s_q.irq;
    assign burst_bytes = s_q.burst;

endmodule

// File: rtl/fti_chk.sv
module fti_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fifo_level,
    input logic          host_wr,
    input logic          host_addr,
    input logic          irq,
    input logic [CW-1:0] burst_bytes,
    input logic          dma_q,
    input logic          svc_q
);

    // R4
    rise_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(fifo_level) != '0));

    // R5
    rise_needs_pio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(dma_q) == 1'b0 && $past(svc_q) == 1'b0));

    // R6
    idle_burst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (burst_bytes == '0));

    // R6
    full_burst_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && burst_bytes == CW'(DEPTH)) |-> ($past(fifo_level) >= CW'(DEPTH)));

    // R6
    burst_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (burst_bytes != '0 && burst_bytes <= CW'(DEPTH)));

    // R7
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(host_wr && host_addr)) |=> (irq && $stable(burst_bytes)));

    // R8
    ctl_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr) |=> !irq);

endmodule

bind fifo_rd_irq_gen fti_chk #(.DEPTH(DEPTH)) u_fti_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_level  (fifo_level),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .irq         (irq),
    .burst_bytes (burst_bytes),
    .dma_q       (s_q.dma),
    .svc_q       (s_q.svc)
);

// File: tb/tb_fifo_rd_irq_gen.sv
`timescale 1ns/1ps
module tb_fifo_rd_irq_gen;

    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] fifo_level = '0;
    logic          host_wr = 1'b0;
    logic          host_addr = 1'b0;
    logic [CW-1:0] host_wdata = '0;
    logic          irq;
    logic [CW-1:0] burst_bytes;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fifo_rd_irq_gen #(.DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_level  (fifo_level),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .irq         (irq),
        .burst_bytes (burst_bytes)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic write_reg(input logic addr, input int data);
        host_wr    = 1'b1;
        host_addr  = addr;
        host_wdata = CW'(data);
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int rd_thr(input int p);
        return DEPTH - ((p >= DEPTH - 1) ? DEPTH - 1 : p);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the outputs
        check("R1 irq after reset", irq, 0);
        check("R1 burst after reset", burst_bytes, 0);
        fifo_level = 5'd15;
        edges(3);
        check("R1 threshold 0 needs 16 bytes", irq, 0);
        fifo_level = 5'd16;
        edges(1);
        check("R1 full FIFO fires from reset", irq, 1);
        check("R1 burst full from reset", burst_bytes, 16);

        // R2 R3 R4 R6: sweep every threshold against every level
        for (int p = 0; p <= 16; p++) begin
            for (int l = 0; l <= 16; l++) begin
                int rt;
                int exp_irq;
                int exp_burst;
                rt        = rd_thr(p);
                exp_irq   = (l >= rt) ? 1 : 0;
                exp_burst = exp_irq ? ((l == DEPTH) ? DEPTH : rt) : 0;
                write_reg(1'b1, 2);
                write_reg(1'b0, p);
                fifo_level = CW'(l);
                write_reg(1'b1, 0);
                check("R8 cleared by control write", irq, 0);
                edges(1);
                check($sformatf("R2 R3 R4 irq p=%0d l=%0d", p, l), irq, exp_irq);
                check($sformatf("R6 burst p=%0d l=%0d", p, l), burst_bytes, exp_burst);
            end
        end

        // R4: one-edge latency from a level change
        write_reg(1'b1, 2);
        write_reg(1'b0, 4);
        fifo_level = 5'd0;
        write_reg(1'b1, 0);
        edges(2);
        check("R4 idle below threshold", irq, 0);
        fifo_level = 5'd14;
        #1;
        check("R4 no change before edge", irq, 0);
        edges(1);
        check("R4 irq one edge after level", irq, 1);
        check("R6 burst is threshold when not full", burst_bytes, 12);

        // R7: latched through level changes
        fifo_level = 5'd16;
        edges(3);
        check("R7 irq held", irq, 1);
        check("R7 burst held at fire value", burst_bytes, 12);
        fifo_level = 5'd0;
        edges(3);
        check("R7 irq held at empty", irq, 1);

        // R8: refire when condition still holds, none when it does not
        fifo_level = 5'd13;
        write_reg(1'b1, 0);
        check("R8 clear on write edge", irq, 0);
        edges(1);
        check("R8 refires", irq, 1);
        check("R8 refire burst", burst_bytes, 12);
        fifo_level = 5'd5;
        write_reg(1'b1, 0);
        edges(4);
        check("R8 no refire below threshold", irq, 0);
        check("R8 burst idle", burst_bytes, 0);

        // R9: host-set service bit masks
        fifo_level = 5'd16;
        write_reg(1'b1, 2);
        edges(4);
        check("R9 masked full FIFO", irq, 0);

        // R5: DMA enable suppresses
        write_reg(1'b1, 1);
        edges(4);
        check("R5 dma suppresses", irq, 0);
        check("R5 burst idle", burst_bytes, 0);
        write_reg(1'b1, 0);
        edges(1);
        check("R5 fires after dma off", irq, 1);
        check("R6 full burst after dma off", burst_bytes, 16);

        // R3: out-of-range value saturates
        write_reg(1'b1, 2);
        write_reg(1'b0, 31);
        fifo_level = 5'd1;
        write_reg(1'b1, 0);
        edges(1);
        check("R3 value 31 acts as 15", irq, 1);
        check("R3 burst one byte", burst_bytes, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule